// File: doc/BRIEF.md
# Audio Sample-Stamp Timing Generator

This block places audio frames on a time axis measured by a fast reference clock. An asynchronous word clock first passes through a two-flop synchronizer, and only its rising edges are used. Two counters run from those edges. A word counter counts frames and wraps at a programmed period, so it tracks the position in a circular sample buffer. A fast counter counts reference-clock cycles since the most recent word-clock edge. On every edge the length of the period that just ended is latched, and the block also keeps the smallest period seen since the last clear. A spurious extra word-clock pulse therefore shows up as a minimum that is much smaller than the typical period.

An external event pulse captures both counters, which gives a frame index plus a fractional position inside the frame. Software can move the word counter without losing an edge that lands in the same cycle: it can load an absolute value, or add an offset modulo the period. An offset of the period minus n steps the counter back by n.

The input and output streams are armed separately by a configuration strobe. Each stream reports ready once its preconditions are met. The stream then emits a one-cycle start pulse when the word counter equals its compare value. A sticky flag reports a word clock that has stopped.

Top module: `sstamp_gen`

## Requirements
- R1: A rising edge on `wclk_in` is counted through a two-flop synchronizer. When `wclk_in` is driven high before clock edge k, the counters change at edge k+2.
- R2: While `en` is high, `xcnt` increases by one per clock and saturates at all ones. A counted word-clock edge sets `xcnt` to 0.
- R3: On each counted edge, `xper` takes the value `xcnt`+1, saturated at all ones. This is the number of clocks in the period that just ended.
- R4: On each counted edge, `xper_min` takes the new period if that period is smaller than the stored minimum. A `min_clr` strobe sets `xper_min` to all ones, and it wins over an update in the same cycle.
- R5: `wcnt` increases by one on each counted edge and wraps to 0 when it reaches `per_cfg`. A `per_cfg` of 0 lets it run over the full counter range.
- R6: `set_stb` loads `wcnt` with `set_val` on the next clock. A word-clock edge counted in that same cycle is dropped, and a set wins over an add.
- R7: `add_stb` makes the next `wcnt` equal to `wcnt` + `add_val` + (1 if an edge is counted in that cycle), reduced once modulo `per_cfg`.
- R8: An `evt` pulse copies the current `wcnt` into `cap_w` and the current `xcnt` into `cap_x`. Both copies are visible one clock later.
- R9: While `en` is low, these outputs are held at 0: `wcnt`, `xcnt`, `xper`, `cap_w`, `cap_x`, the timeout flag and both stream states. `xper_min` is held at all ones. Reset gives the same state.
- R10: A `cfg_stb` arms the input stream when `in_dir` is 1. `in_rdy` goes high once TICKS `bclk_tick` pulses have arrived after that strobe. No start is issued before then.
- R11: A `cfg_stb` arms the output stream when `out_dir` is 1. `out_rdy` additionally needs PRELOAD `smp_load` pulses after that strobe.
- R12: When a stream is ready and `wcnt` equals its trigger value, the matching start output pulses for exactly one clock. The ready flag drops in that same clock, and the stream does not start again until it is re-armed.
- R13: `timeout` goes high after TIMEOUT consecutive enabled clocks with no counted edge. It stays high until `en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable; low clears all state |
| wclk_in | input | 1 | Asynchronous word clock |
| bclk_tick | input | 1 | One pulse per bit-clock tick |
| evt | input | 1 | Capture event pulse |
| min_clr | input | 1 | Restore minimum period to all ones |
| set_stb | input | 1 | Load word counter |
| set_val | input | CW | Value for the load |
| add_stb | input | 1 | Add to word counter |
| add_val | input | CW | Value for the add |
| per_cfg | input | CW | Word counter modulo, 0 = full range |
| cfg_stb | input | 1 | Arm the streams selected by the direction inputs |
| in_dir | input | 1 | Input stream in use |
| out_dir | input | 1 | Output stream in use |
| smp_load | input | 1 | One output sample preloaded |
| in_trig | input | CW | Input stream start compare value |
| out_trig | input | CW | Output stream start compare value |
| wcnt | output | CW | Word counter |
| xcnt | output | CW | Fast counter |
| xper | output | CW | Previous period length |
| xper_min | output | CW | Minimum period since last clear |
| cap_w | output | CW | Captured word counter |
| cap_x | output | CW | Captured fast counter |
| in_rdy | output | 1 | Input stream ready to start |
| out_rdy | output | 1 | Output stream ready to start |
| in_start | output | 1 | Input stream start pulse |
| out_start | output | 1 | Output stream start pulse |
| timeout | output | 1 | Sticky missing word-clock flag |

## Verification
The bench builds the block with CW = 8, TIMEOUT = 40, TICKS = 4 and PRELOAD = 2. The 8-bit counters let a few hundred clocks drive the fast counter into saturation and the full-range wrap of the word counter. The short timeout puts the exact cycle in which the missing-clock flag rises in plain view, instead of after 65535 cycles. The small tick and preload counts make the thresholds for both ready flags quick to reach, and they let the bench check one step below and one step at each threshold.

// File: rtl/sstamp_gen.sv
module sstamp_gen #(
  parameter int CW      = 16,
  parameter int TIMEOUT = 65535,
  parameter int TICKS   = 32,
  parameter int PRELOAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wclk_in,
  input  logic          bclk_tick,
  input  logic          evt,
  input  logic          min_clr,
  input  logic          set_stb,
  input  logic [CW-1:0] set_val,
  input  logic          add_stb,
  input  logic [CW-1:0] add_val,
  input  logic [CW-1:0] per_cfg,
  input  logic          cfg_stb,
  input  logic          in_dir,
  input  logic          out_dir,
  input  logic          smp_load,
  input  logic [CW-1:0] in_trig,
  input  logic [CW-1:0] out_trig,
  output logic [CW-1:0] wcnt,
  output logic [CW-1:0] xcnt,
  output logic [CW-1:0] xper,
  output logic [CW-1:0] xper_min,
  output logic [CW-1:0] cap_w,
  output logic [CW-1:0] cap_x,
  output logic          in_rdy,
  output logic          out_rdy,
  output logic          in_start,
  output logic          out_start,
  output logic          timeout
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int KW = $clog2(TICKS + 1);
  localparam int PW = $clog2(PRELOAD + 1);

  logic [1:0]    wsync;
  logic          wprev;
  logic [TW-1:0] gap;
  logic [KW-1:0] tick_cnt;
  logic [PW-1:0] pre_cnt;
  logic          in_pend, out_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wsync <= '0;
      wprev <= 1'b0;
    end else begin
      wsync <= {wsync[0], wclk_in};
      wprev <= wsync[1];
    end

  wire rise = en & wsync[1] & ~wprev;

  wire [CW-1:0] xnext = (xcnt == MAXV) ? MAXV : xcnt + 1'b1;
  wire [CW:0]   wsum  = {1'b0, wcnt} + (add_stb ? {1'b0, add_val} : '0) + {{CW{1'b0}}, rise};
  wire [CW-1:0] wnext = set_stb ? set_val
                      : CW'((wsum >= {1'b0, per_cfg}) ? wsum - {1'b0, per_cfg} : wsum);
  wire [TW-1:0] gap_nx = rise ? '0 : ((gap == TW'(TIMEOUT)) ? gap : gap + 1'b1);

  wire ticks_ok = (tick_cnt == KW'(TICKS));
  wire pre_ok   = (pre_cnt == PW'(PRELOAD));
  assign in_rdy  = in_pend & ticks_ok;
  assign out_rdy = out_pend & ticks_ok & pre_ok;
  wire in_hit  = in_rdy & (wcnt == in_trig) & ~cfg_stb;
  wire out_hit = out_rdy & (wcnt == out_trig) & ~cfg_stb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt <= '0; xcnt <= '0; xper <= '0; xper_min <= MAXV;
      cap_w <= '0; cap_x <= '0; gap <= '0; timeout <= 1'b0;
    end else if (!en) begin
      wcnt <= '0; xcnt <= '0; xper <= '0; xper_min <= MAXV;
      cap_w <= '0; cap_x <= '0; gap <= '0; timeout <= 1'b0;
    end else begin
      wcnt <= wnext;
      xcnt <= rise ? '0 : xnext;
      if (rise) xper <= xnext;
      if (min_clr) xper_min <= MAXV;
      else if (rise && xnext < xper_min) xper_min <= xnext;
      if (evt) begin
        cap_w <= wcnt;
        cap_x <= xcnt;
      end
      gap <= gap_nx;
      timeout <= timeout | (gap_nx == TW'(TIMEOUT));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_pend <= 1'b0; out_pend <= 1'b0; tick_cnt <= '0; pre_cnt <= '0;
      in_start <= 1'b0; out_start <= 1'b0;
    end else if (!en) begin
      in_pend <= 1'b0; out_pend <= 1'b0; tick_cnt <= '0; pre_cnt <= '0;
      in_start <= 1'b0; out_start <= 1'b0;
    end else begin
      in_start  <= in_hit;
      out_start <= out_hit;
      if (cfg_stb) begin
        in_pend  <= in_dir;
        out_pend <= out_dir;
        tick_cnt <= '0;
        pre_cnt  <= '0;
      end else begin
        if (bclk_tick && !ticks_ok) tick_cnt <= tick_cnt + 1'b1;
        if (smp_load && !pre_ok) pre_cnt <= pre_cnt + 1'b1;
        if (in_hit) in_pend <= 1'b0;
        if (out_hit) out_pend <= 1'b0;
      end
    end

  // R2
  xcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise) |=> (xcnt == '0));
  // R4
  min_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && !min_clr) |=> (xper_min <= xper));
  // R4
  min_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && min_clr) |=> (xper_min == MAXV));
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wcnt == '0 && cap_w == '0 && cap_x == '0 && !timeout && !in_start));
  // R12
  in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_start |-> (!in_rdy && $past(wcnt) == $past(in_trig)));
  // R12
  out_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (!out_rdy && $past(wcnt) == $past(out_trig)));
  // R13
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && timeout) |=> timeout);
endmodule

// File: tb/sstamp_gen_test.sv
module sstamp_gen_test;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, en = 0, wclk_in = 0, bclk_tick = 0, evt = 0, min_clr = 0;
  logic set_stb = 0, add_stb = 0, cfg_stb = 0, in_dir = 0, out_dir = 0, smp_load = 0;
  logic [CW-1:0] set_val = 0, add_val = 0, per_cfg = 0, in_trig = 0, out_trig = 0;
  logic [CW-1:0] wcnt, xcnt, xper, xper_min, cap_w, cap_x;
  logic in_rdy, out_rdy, in_start, out_start, timeout;
  int tests = 0, fails = 0;
  int in_hits = 0, out_hits = 0, in_at = -1, out_at = -1;

  always #10 clk = ~clk;

  sstamp_gen #(.CW(CW), .TIMEOUT(40), .TICKS(4), .PRELOAD(2)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .wclk_in(wclk_in), .bclk_tick(bclk_tick),
    .evt(evt), .min_clr(min_clr), .set_stb(set_stb), .set_val(set_val),
    .add_stb(add_stb), .add_val(add_val), .per_cfg(per_cfg), .cfg_stb(cfg_stb),
    .in_dir(in_dir), .out_dir(out_dir), .smp_load(smp_load), .in_trig(in_trig),
    .out_trig(out_trig), .wcnt(wcnt), .xcnt(xcnt), .xper(xper), .xper_min(xper_min),
    .cap_w(cap_w), .cap_x(cap_x), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .in_start(in_start), .out_start(out_start), .timeout(timeout));

  always @(negedge clk) begin
    if (in_start) begin in_hits++; in_at = int'(wcnt); end
    if (out_start) begin out_hits++; out_at = int'(wcnt); end
  end

  // gap, pulse count, modulo, expected wcnt
  localparam int VEC [4][4] = '{'{10, 5, 0, 5}, '{7, 9, 4, 1}, '{12, 3, 3, 0}, '{5, 6, 100, 6}};

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(int per);
    en = 0; @(negedge clk);
    per_cfg = CW'(per); en = 1;
  endtask

  // op: 0 none, 1 min_clr, 2 set, 3 add; strobe lands on the counting edge
  task automatic wpulse(int gap, int op, int val);
    wclk_in = 1; @(negedge clk); @(negedge clk);
    wclk_in = 0;
    case (op)
      1: min_clr = 1;
      2: begin set_stb = 1; set_val = CW'(val); end
      3: begin add_stb = 1; add_val = CW'(val); end
      default: ;
    endcase
    @(negedge clk);
    min_clr = 0; set_stb = 0; add_stb = 0;
    repeat (gap - 3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R9 reset wcnt", int'(wcnt), 0);
    chk("R9 reset xper_min", int'(xper_min), 255);
    chk("R9 reset timeout/rdy", int'({timeout, in_rdy, out_rdy}), 0);

    for (int i = 0; i < 4; i++) begin
      restart(VEC[i][2]);
      for (int k = 0; k < VEC[i][1]; k++) wpulse(VEC[i][0], 0, 0);
      chk("R5 wcnt modulo", int'(wcnt), VEC[i][3]);
      chk("R3 period", int'(xper), VEC[i][0]);
    end

    restart(0);
    wclk_in = 1; @(negedge clk); @(negedge clk);
    chk("R1 no count after two edges", int'(wcnt), 0);
    @(negedge clk);
    chk("R1 count on third edge", int'(wcnt), 1);
    wclk_in = 0; repeat (4) @(negedge clk);

    restart(0);
    repeat (3) wpulse(8, 0, 0);
    chk("R2 xcnt since edge", int'(xcnt), 5);
    evt = 1; @(negedge clk); evt = 0;
    chk("R8 cap_w", int'(cap_w), 3);
    chk("R8 cap_x", int'(cap_x), 5);

    per_cfg = 10;
    set_stb = 1; set_val = 3; @(negedge clk); set_stb = 0;
    chk("R6 set", int'(wcnt), 3);
    add_stb = 1; add_val = 5; @(negedge clk); add_stb = 0;
    chk("R7 add", int'(wcnt), 8);
    wpulse(6, 3, 4);
    chk("R7 add with edge wraps", int'(wcnt), 3);
    wpulse(6, 2, 7);
    chk("R6 set drops edge", int'(wcnt), 7);
    set_stb = 1; set_val = 9; @(negedge clk); set_stb = 0;
    wpulse(6, 0, 0);
    chk("R5 wrap at period", int'(wcnt), 0);

    restart(0);
    wpulse(9, 1, 0);
    chk("R4 clear wins over update", int'(xper_min), 255);
    wpulse(9, 0, 0); wpulse(9, 0, 0);
    chk("R4 min 9", int'(xper_min), 9);
    wpulse(6, 0, 0); wpulse(6, 0, 0);
    chk("R4 min 6", int'(xper_min), 6);
    wpulse(11, 0, 0); wpulse(11, 0, 0);
    chk("R4 min kept", int'(xper_min), 6);
    chk("R3 period 11", int'(xper), 11);
    min_clr = 1; @(negedge clk); min_clr = 0;
    chk("R4 min_clr", int'(xper_min), 255);

    restart(0);
    repeat (39) @(negedge clk);
    chk("R13 no timeout at 39", int'(timeout), 0);
    @(negedge clk);
    chk("R13 timeout at 40", int'(timeout), 1);
    repeat (260) @(negedge clk);
    chk("R2 xcnt saturates", int'(xcnt), 255);
    wpulse(5, 0, 0);
    chk("R3 saturated period", int'(xper), 255);
    chk("R13 sticky", int'(timeout), 1);
    en = 0; @(negedge clk);
    chk("R9 disable clears", int'({timeout, wcnt, xper}), 0);
    chk("R9 disable clears captures", int'({cap_w, cap_x}), 0);

    restart(0);
    in_trig = 5; out_trig = 7; in_dir = 1; out_dir = 1;
    cfg_stb = 1; @(negedge clk); cfg_stb = 0;
    set_stb = 1; set_val = 5; @(negedge clk); set_stb = 0;
    repeat (3) @(negedge clk);
    chk("R10 no start before ticks", in_hits, 0);
    set_stb = 1; set_val = 0; @(negedge clk); set_stb = 0;
    repeat (3) begin bclk_tick = 1; @(negedge clk); bclk_tick = 0; @(negedge clk); end
    chk("R10 not ready at 3 ticks", int'(in_rdy), 0);
    bclk_tick = 1; @(negedge clk); bclk_tick = 0;
    chk("R10 ready at 4 ticks", int'(in_rdy), 1);
    chk("R11 out waits for preload", int'(out_rdy), 0);
    smp_load = 1; @(negedge clk); smp_load = 0;
    chk("R11 one sample not enough", int'(out_rdy), 0);
    smp_load = 1; @(negedge clk); smp_load = 0;
    chk("R11 ready after preload", int'(out_rdy), 1);
    repeat (9) wpulse(5, 0, 0);
    chk("R12 in start once", in_hits, 1);
    chk("R12 in start at trigger", in_at, 5);
    chk("R12 out start once", out_hits, 1);
    chk("R12 out start at trigger", out_at, 7);
    chk("R12 ready dropped", int'({in_rdy, out_rdy}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule